// File: doc/BRIEF.md
# Page Write Buffer Controller

This block sits behind the serial protocol front end of a small non-volatile memory and handles the write path. Once the front end has seen a start condition, it sends the byte address and then a stream of data bytes, one strobe per byte. The block keeps those bytes in a one-row staging buffer. A row is 2^ROW_W bytes, 16 by default. Only the low address bits move as bytes arrive, so a load that runs past the end of the row wraps back to the row's first byte. A later byte written to a position replaces the earlier one.

The front end raises a commit pulse only when a stop condition lands in the bit slot right after an acknowledge. Commit starts a self-timed programming cycle. The busy flag stays high for the whole cycle, and the front end uses it to withhold acknowledges. When the cycle ends, every row position that received a byte is written into the storage array in one step. Positions that received no byte keep their old contents. Any other stop appears as an abort pulse and drops the buffered bytes.

A write-inhibit input can block the write. If it is seen at any time from the start condition up to and including the address strobe, the frame cannot change the array, and each data byte of that frame is flagged as not acknowledged. The storage array is an internal register file. Its read port lets the surrounding read logic fetch bytes.

Top module: `pgwr_ctrl`

## Requirements
- R1: After reset, every array byte reads 8'hFF and `busy_o` is low.
- R2: A frame with one data byte followed by commit writes that byte at the loaded address. The other positions of that row keep their contents.
- R3: Consecutive data bytes go to consecutive positions within the row, starting at the low bits of the loaded address. A load of 16 bytes fills the whole row.
- R4: Position arithmetic is modulo the row size and the upper address bits never change. Byte k of a frame (k from 0) lands at position (start + k) mod 16, and a later byte replaces an earlier byte at the same position.
- R5: An abort pulse ends the frame without any array change and without raising `busy_o`.
- R6: If `wr_inhibit_i` is high in any cycle from `frame_start_i` through `addr_vld_i`, the frame leaves the array unchanged. Each data strobe of that frame gives `data_nack_o` = 1 in the cycle after the strobe. Inhibit raised only after the address strobe has no effect: the bytes are written and `data_nack_o` stays 0.
- R7: A commit accepted in the cycle with edge E0 makes `busy_o` high from E0 on, for exactly PROG_CYCLES+1 clock cycles. The array keeps its old contents until the cycle in which `busy_o` falls, and at that point the new contents are visible.
- R8: While `busy_o` is high, the frame start, address, data, commit and abort inputs are ignored. They neither change the array nor start a second cycle.
- R9: The record of which row positions are loaded is cleared on every frame start. Bytes loaded in a frame that is restarted without a stop are never written, even into the same row.
- R10: A commit in a frame that loaded no data bytes starts no programming cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start_i | input | 1 | Start condition seen (pulse) |
| wr_inhibit_i | input | 1 | Write-inhibit level |
| addr_vld_i | input | 1 | Byte address strobe |
| addr_i | input | ADDR_W | Byte address |
| data_vld_i | input | 1 | Data byte strobe |
| data_i | input | 8 | Data byte |
| commit_i | input | 1 | Stop in the slot after an acknowledge (pulse) |
| abort_i | input | 1 | Stop at any other moment (pulse) |
| rd_addr_i | input | ADDR_W | Array read address |
| busy_o | output | 1 | Programming cycle in progress |
| data_nack_o | output | 1 | Last data byte is not acknowledged |
| rd_data_o | output | 8 | Array byte at `rd_addr_i` |

## Verification
The table-driven frames cover several load patterns. A single byte shows that only the addressed position changes. A full row starting mid-row shows that the position wraps. A 20-byte load shows that a later byte overwrites an earlier one. Other frames cover inhibit raised at the start condition versus inhibit raised during the data bytes, an aborted frame, and a frame with no data bytes, which separates "committed" from "programmed". Each of these frames is judged by reading back the whole row against a bench shadow array, and by counting how many cycles busy stays high. Directed tests cover the reset contents, array contents before and after busy falls, stimulus sent during busy, and a restarted frame within one row.

// File: rtl/pgwr_pkg.sv
// Shared types for the page write buffer controller.
package pgwr_pkg;
    // Frame phase: waiting for start, waiting for address, taking data.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;
endpackage

// File: rtl/pgwr_buffer.sv
// Row staging buffer: one byte register and one loaded flag per row position.
// Assumes clr_i and ld_i come from the controller; clr_i wins if both are high.
module pgwr_buffer #(
    parameter int ROW_W = 4,
    localparam int ROW_N = 1 << ROW_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 ld_i,
    input  logic [ROW_W-1:0]     pos_i,
    input  logic [7:0]           data_i,
    output logic [ROW_N-1:0]     mask_o,
    output logic [ROW_N*8-1:0]   data_o
);
    genvar g;
    generate
        for (g = 0; g < ROW_N; g++) begin : g_ent
            logic [7:0] byte_q;
            logic       vld_q;
            // Hold the byte and its loaded flag for row position g.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    byte_q <= '0;
                    vld_q  <= 1'b0;
                end else if (clr_i) begin
                    vld_q  <= 1'b0;
                end else if (ld_i && pos_i == ROW_W'(g)) begin
                    byte_q <= data_i;
                    vld_q  <= 1'b1;
                end
            end
            assign mask_o[g]          = vld_q;
            assign data_o[g*8 +: 8]   = byte_q;
        end
    endgenerate

    // R9
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (mask_o == '0));
endmodule

// File: rtl/pgwr_timer.sv
// Self-timed programming cycle counter. Loads PROG_CYCLES on start_i and counts down.
// busy_o falls in the cycle after the count reaches zero. done_o marks the last busy cycle.
// Assumes start_i is never high while busy_o is high.
module pgwr_timer #(
    parameter int PROG_CYCLES = 24,
    localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load on start, then count down to zero and release busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_o <= 1'b0;
        end else if (start_i && !busy_o) begin
            cnt_q  <= CNT_W'(PROG_CYCLES);
            busy_o <= 1'b1;
        end else if (busy_o) begin
            if (cnt_q == '0) busy_o <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign done_o = busy_o && (cnt_q == '0);

    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cnt_q != '0) |=> busy_o);
    // R7
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(PROG_CYCLES));
endmodule

// File: rtl/pgwr_array.sv
// Byte-wide storage array as a register file. All bytes reset to 8'hFF.
// A row write updates only the positions set in mask_i. The read port is combinational.
module pgwr_array #(
    parameter int ADDR_W = 8,
    parameter int ROW_W  = 4,
    localparam int ROW_N  = 1 << ROW_W,
    localparam int ADDR_N = 1 << ADDR_W,
    localparam int HI_W   = ADDR_W - ROW_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [HI_W-1:0]      row_i,
    input  logic [ROW_N-1:0]     mask_i,
    input  logic [ROW_N*8-1:0]   wdata_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic [7:0]           rd_data_o
);
    logic [7:0] mem [ADDR_N];

    // Reset to erased state; commit loaded positions of one row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < ADDR_N; a++) mem[a] <= 8'hFF;
        end else if (wr_en_i) begin
            for (int p = 0; p < ROW_N; p++) begin
                if (mask_i[p]) mem[{row_i, ROW_W'(p)}] <= wdata_i[p*8 +: 8];
            end
        end
    end

    assign rd_data_o = mem[rd_addr_i];

    // R5
    array_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en_i) && $stable(rd_addr_i)) |-> $stable(rd_data_o));
endmodule

// File: rtl/pgwr_ctrl.sv
// Page write buffer controller (top). Tracks the frame phase, latches the row and
// position, collects write inhibit up to the address strobe, flags inhibited data
// bytes, and starts the self-timed cycle that commits the buffer to the array.
// Assumes the front end sends single-cycle pulses and ignores nothing itself while busy.
module pgwr_ctrl #(
    parameter int ADDR_W      = 8,
    parameter int ROW_W       = 4,
    parameter int PROG_CYCLES = 24,
    localparam int ROW_N = 1 << ROW_W,
    localparam int HI_W  = ADDR_W - ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic              wr_inhibit_i,
    input  logic              addr_vld_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              data_vld_i,
    input  logic [7:0]        data_i,
    input  logic              commit_i,
    input  logic              abort_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              busy_o,
    output logic              data_nack_o,
    output logic [7:0]        rd_data_o
);
    import pgwr_pkg::*;

    phase_e             phase_q;
    logic [HI_W-1:0]    row_q;
    logic [ROW_W-1:0]   pos_q;
    logic               inhib_q;
    logic [ROW_N-1:0]   mask;
    logic [ROW_N*8-1:0] bdata;
    logic               buf_clr, buf_ld, prog_start, prog_done;
    logic               in_data;

    // Qualify inputs: nothing is accepted while the programming cycle runs.
    always_comb begin
        in_data    = !busy_o && !frame_start_i && (phase_q == PH_DATA);
        buf_clr    = !busy_o && frame_start_i;
        buf_ld     = in_data && data_vld_i && !inhib_q;
        prog_start = in_data && commit_i && !inhib_q && (mask != '0);
    end

    // Frame phase, row/position capture, inhibit window and data nack flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            row_q       <= '0;
            pos_q       <= '0;
            inhib_q     <= 1'b0;
            data_nack_o <= 1'b0;
        end else if (busy_o) begin
            data_nack_o <= 1'b0;
        end else begin
            data_nack_o <= in_data && data_vld_i && inhib_q;
            if (frame_start_i) begin
                phase_q <= PH_ADDR;
                inhib_q <= wr_inhibit_i;
            end else begin
                unique case (phase_q)
                    PH_ADDR: begin
                        inhib_q <= inhib_q | wr_inhibit_i;
                        if (addr_vld_i) begin
                            row_q   <= addr_i[ADDR_W-1:ROW_W];
                            pos_q   <= addr_i[ROW_W-1:0];
                            phase_q <= PH_DATA;
                        end
                        if (commit_i || abort_i) phase_q <= PH_IDLE;
                    end
                    PH_DATA: begin
                        if (data_vld_i) pos_q <= pos_q + 1'b1;
                        if (commit_i || abort_i) phase_q <= PH_IDLE;
                    end
                    default: ;
                endcase
            end
        end
    end

    pgwr_buffer #(.ROW_W(ROW_W)) buf_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (buf_clr),
        .ld_i   (buf_ld),
        .pos_i  (pos_q),
        .data_i (data_i),
        .mask_o (mask),
        .data_o (bdata)
    );

    pgwr_timer #(.PROG_CYCLES(PROG_CYCLES)) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (prog_start),
        .busy_o  (busy_o),
        .done_o  (prog_done)
    );

    pgwr_array #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) arr_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (prog_done),
        .row_i     (row_q),
        .mask_i    (mask),
        .wdata_i   (bdata),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );

    // R7
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(commit_i));
    // R6
    nack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_nack_o |-> ($past(data_vld_i) && !busy_o));
endmodule

// File: tb/pgwr_ctrl_tb.sv
module pgwr_ctrl_tb_top;
    localparam int PROG = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 0, wr_inhibit = 0, addr_vld = 0, data_vld = 0;
    logic       commit = 0, abort = 0;
    logic [7:0] addr = 0, data = 0, rd_addr = 0;
    logic       busy, nack;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] model [256];

    always #4 clk = ~clk;

    pgwr_ctrl #(.ADDR_W(8), .ROW_W(4), .PROG_CYCLES(PROG)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start), .wr_inhibit_i(wr_inhibit),
        .addr_vld_i(addr_vld), .addr_i(addr), .data_vld_i(data_vld), .data_i(data),
        .commit_i(commit), .abort_i(abort), .rd_addr_i(rd_addr),
        .busy_o(busy), .data_nack_o(nack), .rd_data_o(rd_data)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    typedef struct packed {
        logic [7:0] addr;
        logic [5:0] n;
        logic [7:0] seed;
        logic [1:0] inh;   // 0 none, 1 at start only, 2 during data bytes
        logic       abrt;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{8'h00, 6'd1,  8'h11, 2'd0, 1'b0},   // R2
        '{8'h23, 6'd16, 8'h40, 2'd0, 1'b0},   // R3
        '{8'h5C, 6'd20, 8'h80, 2'd0, 1'b0},   // R4
        '{8'h70, 6'd4,  8'h33, 2'd1, 1'b0},   // R6 early inhibit
        '{8'h90, 6'd3,  8'h55, 2'd0, 1'b1},   // R5
        '{8'hA4, 6'd2,  8'h66, 2'd2, 1'b0},   // R6 late inhibit
        '{8'hF0, 6'd0,  8'h00, 2'd0, 1'b0}    // R10
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic send_start(input bit inh);
        frame_start = 1; wr_inhibit = inh;
        @(negedge clk);
        frame_start = 0; wr_inhibit = 0;
    endtask

    task automatic send_addr(input logic [7:0] a);
        addr_vld = 1; addr = a;
        @(negedge clk);
        addr_vld = 0;
    endtask

    task automatic send_byte(input logic [7:0] d, input bit inh, input bit do_chk,
                             input bit exp_nack, input string req);
        data_vld = 1; data = d; wr_inhibit = inh;
        @(negedge clk);
        data_vld = 0; wr_inhibit = 0;
        if (do_chk) chk(nack == exp_nack, req, nack, exp_nack);
    endtask

    task automatic send_end(input bit abrt);
        if (abrt) abort = 1; else commit = 1;
        @(negedge clk);
        abort = 0; commit = 0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic check_row(input logic [3:0] row, input string req);
        for (int p = 0; p < 16; p++) begin
            rd_addr = {row, 4'(p)};
            #1;
            chk(rd_data == model[{row, 4'(p)}], req, rd_data, model[{row, 4'(p)}]);
        end
    endtask

    initial begin
        int n;
        for (int a = 0; a < 256; a++) model[a] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        chk(busy == 1'b0, "R1 busy", busy, 0);
        begin
            int bad = 0;
            for (int a = 0; a < 256; a++) begin
                rd_addr = 8'(a);
                #1;
                if (rd_data != 8'hFF) bad++;
            end
            chk(bad == 0, "R1 erased bytes", bad, 0);
        end

        // Table of frames
        for (int v = 0; v < 7; v++) begin
            vec_t e = VECS[v];
            bit wr_exp;
            send_start(e.inh == 2'd1);
            send_addr(e.addr);
            for (int k = 0; k < int'(e.n); k++)
                send_byte(e.seed + 8'(k * 7), e.inh == 2'd2, 1'b1, e.inh == 2'd1, "R6 nack");
            send_end(e.abrt);
            wr_exp = !e.abrt && (e.n != 0) && (e.inh != 2'd1);
            wait_idle(n);
            chk(n == (wr_exp ? PROG + 1 : 0), "R7/R10 busy length", n, wr_exp ? PROG + 1 : 0);
            if (wr_exp)
                for (int k = 0; k < int'(e.n); k++)
                    model[{e.addr[7:4], 4'(int'(e.addr[3:0]) + k)}] = e.seed + 8'(k * 7);
            check_row(e.addr[7:4], "R2/R3/R4/R5/R6/R10 row contents");
        end

        // R7: array unchanged while busy, updated when busy falls
        send_start(0); send_addr(8'hE0); send_byte(8'h3C, 0, 0, 0, "");
        send_end(0);
        rd_addr = 8'hE0; #1;
        chk(busy == 1'b1, "R7 busy raised", busy, 1);
        chk(rd_data == 8'hFF, "R7 old data during busy", rd_data, 8'hFF);
        repeat (PROG) @(negedge clk);
        #1;
        chk(busy == 1'b1 && rd_data == 8'hFF, "R7 last busy cycle", rd_data, 8'hFF);
        @(negedge clk); #1;
        chk(busy == 1'b0, "R7 busy fell", busy, 0);
        chk(rd_data == 8'h3C, "R7 new data at fall", rd_data, 8'h3C);
        model[8'hE0] = 8'h3C;

        // R8: stimulus during busy ignored
        send_start(0); send_addr(8'hB0); send_byte(8'hAA, 0, 0, 0, "");
        send_end(0);
        model[8'hB0] = 8'hAA;
        send_start(0); send_addr(8'hB5); send_byte(8'h77, 0, 0, 0, ""); send_end(0);
        wait_idle(n);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R8 no second cycle", busy, 0);
        check_row(4'hB, "R8 row contents");

        // R9: restarted frame in the same row writes only its own bytes
        send_start(0); send_addr(8'hC0);
        send_byte(8'h01, 0, 0, 0, ""); send_byte(8'h02, 0, 0, 0, "");
        send_start(0); send_addr(8'hC8); send_byte(8'h99, 0, 0, 0, ""); send_end(0);
        wait_idle(n);
        model[8'hC8] = 8'h99;
        check_row(4'hC, "R9 row contents");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule